// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block gathers the fault outputs of six isolated gate drivers in a three-phase power stage and turns them into a single trip. Any raised fault line forces the PWM kill output and all six driver disables high in the same cycle, through a purely combinational path. Firmware timing plays no part in this first stop.

Recovery is handled by a small state machine that runs on the synchronised fault lines. A detected fault moves the handler from CLEAR to TEMP and increments a fault counter. In TEMP a retry timer counts external ticks, and it starts again whenever any fault line is active. When the timer expires, the handler retries through a one-cycle RESET state if the count is still below the limit. If the count has reached the limit, it locks in PERM. PERM is left only through the clear command or the block reset. The wait is set by a parameter given in ticks: 5000 ticks of a 1 kHz strobe give a five-second wait, and simulation can use a few ticks.

The named transitions are: detect (CLEAR→TEMP), retry (TEMP→RESET), escalate (TEMP→PERM), rearm (RESET→CLEAR) and clear (any state→RESET on the command).

Top module: `gdrv_trip_mgr`

## Requirements
- R1: `pwm_kill_o` is high in the same cycle that any bit of `drv_flt_i` is high, with no clock edge in between.
- R2: every bit of `drv_dis_o` equals `pwm_kill_o`, so all six drivers are disabled together, and all are enabled only in CLEAR with no fault line high.
- R3: `state_o` encodes CLEAR=0, TEMP=1, PERM=2, RESET=3. While `rst_n` is low the state is RESET, the kill is high and the count is 0. The first clock edge after reset is released moves the state to CLEAR.
- R4: a fault on any single line, held for SYNC_STAGES+1 clock edges while in CLEAR, moves the state to TEMP and increments `flt_cnt_o` by one. The count increments only on this transition and never exceeds MAX_FAULTS.
- R5: the kill and disables stay high in TEMP, PERM and RESET even after all fault lines have dropped.
- R6: in TEMP, the retry timer counts `tick_i` pulses only while the synchronised fault lines are all low, and it returns to zero while any line is high. The state leaves TEMP on the clock edge that takes the HOLD_TICKS-th counted tick.
- R7: on timer expiry with count below MAX_FAULTS the state goes to RESET, and on the next edge it goes to CLEAR.
- R8: on timer expiry with count equal to MAX_FAULTS the state goes to PERM.
- R9: PERM ignores ticks and the fault lines, and it holds the kill high until `clr_i` is seen.
- R10: `clr_i` high at a clock edge in any state puts the state in RESET and the count at 0. The state stays in RESET while `clr_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_flt_i | input | N_DRV | Fault lines from the gate drivers, active high |
| tick_i | input | 1 | One-cycle timebase strobe for the retry timer |
| clr_i | input | 1 | Clear command; releases a permanent stop and zeroes the count |
| pwm_kill_o | output | 1 | Stops PWM generation, active high |
| drv_dis_o | output | N_DRV | Per-driver disable, active high |
| state_o | output | 2 | Handler state (CLEAR=0, TEMP=1, PERM=2, RESET=3) |
| flt_cnt_o | output | CNT_W | Fault count |

## Verification
Single faults are raised on three different lines, which shows that each line reaches both the combinational trip and the state machine. One retry lets the timer run out with no interruption, to pin down the exact tick that ends TEMP. Another retry raises the fault again partway through the wait, which separates a timer that restarts from one that only pauses. The third fault reaches the limit, so escalation to PERM is told apart from a retry, and PERM is then hit with ticks and idle time to show that it holds. Clear commands are given both from PERM and from TEMP, and one is held for several cycles, to show the counter zeroing and the hold in RESET.

// File: rtl/gdrv_trip_pkg.sv
package gdrv_trip_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_TEMP  = 2'd1,
        ST_PERM  = 2'd2,
        ST_RESET = 2'd3
    } trip_state_e;

endpackage

// File: rtl/gdrv_flt_sync.sv
module gdrv_flt_sync #(
    parameter int N_DRV       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DRV-1:0] flt_raw,
    output logic             flt_any
);

    logic raw_or;
    assign raw_or = |flt_raw;

    generate
        if (SYNC_STAGES == 0) begin : g_bypass
            assign flt_any = raw_or;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q[0] <= raw_or;
                    for (int k = 1; k < SYNC_STAGES; k++) begin
                        stage_q[k] <= stage_q[k-1];
                    end
                end
            end
            assign flt_any = stage_q[SYNC_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gdrv_retry_timer.sv
module gdrv_retry_timer #(
    parameter int HOLD_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic hold,
    input  logic tick,
    output logic expire
);

    localparam int TMR_W = $clog2(HOLD_TICKS + 1);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(HOLD_TICKS - 1);

    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (!run || hold) begin
            tmr_q <= '0;
        end else if (tick && tmr_q != LAST) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign expire = run && !hold && tick && (tmr_q == LAST);

endmodule

// File: rtl/gdrv_flt_counter.sv
module gdrv_flt_counter #(
    parameter int MAX_FAULTS = 3,
    parameter int CNT_W      = $clog2(MAX_FAULTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_FAULTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CAP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_max = (cnt >= CAP);

endmodule

// File: rtl/gdrv_trip_fsm.sv
module gdrv_trip_fsm
    import gdrv_trip_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flt_any,
    input  logic        expire,
    input  logic        at_max,
    input  logic        clr,
    output trip_state_e state,
    output logic        cnt_inc,
    output logic        hold_kill
);

    trip_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (flt_any) state_d = ST_TEMP;
            ST_TEMP:  if (expire)  state_d = at_max ? ST_PERM : ST_RESET;
            ST_PERM:  state_d = ST_PERM;
            ST_RESET: state_d = ST_CLEAR;
            default:  state_d = ST_RESET;
        endcase
        if (clr) state_d = ST_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_inc   = (state_q == ST_CLEAR) && flt_any && !clr;
        hold_kill = (state_q != ST_CLEAR);
        state     = state_q;
    end

endmodule

// File: rtl/gdrv_trip_mgr.sv
module gdrv_trip_mgr
    import gdrv_trip_pkg::*;
#(
    parameter int N_DRV       = 6,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 5000,
    parameter int MAX_FAULTS  = 3,
    parameter int CNT_W       = $clog2(MAX_FAULTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DRV-1:0] drv_flt_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic             pwm_kill_o,
    output logic [N_DRV-1:0] drv_dis_o,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] flt_cnt_o
);

    logic        flt_any;
    logic        expire;
    logic        at_max;
    logic        cnt_inc;
    logic        hold_kill;
    trip_state_e state;

    gdrv_flt_sync #(.N_DRV(N_DRV), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .flt_raw(drv_flt_i), .flt_any(flt_any)
    );

    gdrv_retry_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state == ST_TEMP), .hold(flt_any),
        .tick(tick_i), .expire(expire)
    );

    gdrv_flt_counter #(.MAX_FAULTS(MAX_FAULTS), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .clr(clr_i), .inc(cnt_inc),
        .cnt(flt_cnt_o), .at_max(at_max)
    );

    gdrv_trip_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .flt_any(flt_any), .expire(expire),
        .at_max(at_max), .clr(clr_i), .state(state), .cnt_inc(cnt_inc),
        .hold_kill(hold_kill)
    );

    // immediate trip path: raw lines reach the kill without a register
    always_comb begin
        pwm_kill_o = (|drv_flt_i) | hold_kill;
        drv_dis_o  = {N_DRV{pwm_kill_o}};
        state_o    = state;
    end

endmodule

// File: rtl/gdrv_trip_chk.sv
module gdrv_trip_chk #(
    parameter int N_DRV      = 6,
    parameter int MAX_FAULTS = 3,
    parameter int CNT_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DRV-1:0] drv_flt_i,
    input logic             tick_i,
    input logic             clr_i,
    input logic             pwm_kill_o,
    input logic [N_DRV-1:0] drv_dis_o,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] flt_cnt_o
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_FAULTS);

    AST_KILL_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_flt_i) |-> pwm_kill_o); // R1

    AST_ALL_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |-> (&drv_dis_o)); // R2

    AST_KILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 2'd0) |-> pwm_kill_o); // R5

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        flt_cnt_o <= CAP); // R4

    AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (flt_cnt_o >= $past(flt_cnt_o))); // R4

    AST_WAIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && !tick_i && !clr_i) |=> (state_o == 2'd1)); // R6

    AST_REARM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && !clr_i) |=> (state_o == 2'd0)); // R7

    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && !clr_i) |=> (state_o == 2'd2)); // R9

    AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_o == 2'd3 && flt_cnt_o == '0)); // R10

endmodule

bind gdrv_trip_mgr gdrv_trip_chk #(
    .N_DRV(N_DRV), .MAX_FAULTS(MAX_FAULTS), .CNT_W(CNT_W)
) u_trip_chk (
    .clk(clk), .rst_n(rst_n), .drv_flt_i(drv_flt_i), .tick_i(tick_i),
    .clr_i(clr_i), .pwm_kill_o(pwm_kill_o), .drv_dis_o(drv_dis_o),
    .state_o(state_o), .flt_cnt_o(flt_cnt_o)
);

// File: tb/test_gdrv_trip_mgr.sv
`timescale 1ns/1ps
module test_gdrv_trip_mgr;

    localparam int N_DRV = 6;
    localparam int HOLD  = 4;
    localparam int MAXF  = 3;
    localparam int CW    = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_DRV-1:0] flt = '0;
    logic             tick = 1'b0;
    logic             clr = 1'b0;
    logic             kill;
    logic [N_DRV-1:0] dis;
    logic [1:0]       st;
    logic [CW-1:0]    cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    gdrv_trip_mgr #(.N_DRV(N_DRV), .SYNC_STAGES(2), .HOLD_TICKS(HOLD),
                    .MAX_FAULTS(MAXF), .CNT_W(CW)) i_gdrv_trip_mgr (
        .clk(clk), .rst_n(rst_n), .drv_flt_i(flt), .tick_i(tick), .clr_i(clr),
        .pwm_kill_o(kill), .drv_dis_o(dis), .state_o(st), .flt_cnt_o(cnt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    function automatic void report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endfunction

    task automatic t_reset();
        step(2);
        check("R3 state in reset", st, 3);
        check("R3 kill in reset", kill, 1);
        check("R3 count in reset", cnt, 0);
        rst_n = 1'b1;
        step(1);
        check("R3 state after release", st, 0);
        check("R2 disables low when clear", dis, 0);
    endtask

    task automatic t_fault_retry(input int line, input int exp_cnt);
        flt[line] = 1'b1;
        #1;
        check("R1 kill same cycle", kill, 1);
        check("R2 all disables with kill", dis, 6'h3F);
        step(3);
        check("R4 detect to TEMP", st, 1);
        check("R4 count step", cnt, exp_cnt);
        flt = '0;
        step(3);
        check("R5 kill held in TEMP", kill, 1);
        for (int i = 0; i < HOLD - 1; i++) pulse_tick();
        check("R6 still waiting", st, 1);
        pulse_tick();
        check("R7 retry to RESET", st, 3);
        step(1);
        check("R7 rearm to CLEAR", st, 0);
        check("R7 kill released", kill, 0);
    endtask

    task automatic t_restart(input int line, input int exp_cnt);
        flt[line] = 1'b1;
        step(3);
        check("R4 detect second line", cnt, exp_cnt);
        flt = '0;
        step(3);
        pulse_tick();
        pulse_tick();
        flt[line] = 1'b1;
        step(3);
        flt = '0;
        step(3);
        for (int i = 0; i < HOLD - 1; i++) pulse_tick();
        check("R6 timer restarted by fault", st, 1);
        pulse_tick();
        check("R6 expiry after full wait", st, 3);
        step(1);
        check("R7 rearm after restart", st, 0);
    endtask

    task automatic t_escalate(input int line);
        flt[line] = 1'b1;
        step(3);
        check("R4 count at limit", cnt, MAXF);
        flt = '0;
        step(3);
        for (int i = 0; i < HOLD; i++) pulse_tick();
        check("R8 escalate to PERM", st, 2);
        for (int i = 0; i < 2 * HOLD; i++) pulse_tick();
        step(10);
        check("R9 PERM holds", st, 2);
        check("R9 kill held in PERM", kill, 1);
    endtask

    task automatic t_clear_perm();
        clr = 1'b1;
        step(1);
        check("R10 clear to RESET", st, 3);
        check("R10 count zeroed", cnt, 0);
        step(2);
        check("R10 held in RESET", st, 3);
        clr = 1'b0;
        step(1);
        check("R10 released to CLEAR", st, 0);
        check("R10 kill off after clear", kill, 0);
    endtask

    task automatic t_clear_temp();
        flt[4] = 1'b1;
        step(3);
        check("R4 detect from zero", cnt, 1);
        flt = '0;
        step(3);
        clr = 1'b1;
        step(1);
        clr = 1'b0;
        check("R10 clear from TEMP", st, 3);
        check("R10 count zeroed from TEMP", cnt, 0);
        step(1);
        check("R10 back to CLEAR", st, 0);
    endtask

    initial begin
        t_reset();
        t_fault_retry(0, 1);
        t_restart(5, 2);
        t_escalate(3);
        t_clear_perm();
        t_clear_temp();
        report();
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
        $finish;
    end

endmodule